// File: doc/BRIEF.md
# Priority Vectored Interrupt Arbiter

This block sits between a set of device request lines and a processor that lets interrupts nest. Each request line carries a fixed priority level. The block keeps the processor's current level and lets a request through only when the line's level is strictly above that current level. When several requests qualify in the same cycle, it picks exactly one. For the winner it reports the device code and the byte address of that device's slot in a 32-slot vector table at the bottom of memory. It also sends a one-cycle acknowledge on that device's own line so the device can withdraw its request.

Accepting a request raises the current level to the winner's level, so the same and lower levels are held off while the winner is serviced. The level that was in force before is saved in a small internal stack. A return pulse restores it. Software can also overwrite the current level directly. Reading the vector out of memory is left to the processor.

Top module: `irq_vec_arbiter`

## Requirements
- R1: Line i has priority level i+1, and the current level resets to 0. A line qualifies only while its request is high, the global enable is high, and its level is strictly greater than the current level. A request at an equal or lower level is never accepted.
- R2: While the global enable input is low, no request is accepted, whatever the request lines carry.
- R3: When several lines qualify in the same cycle, the line with the highest index wins.
- R4: An acceptance shows up one clock after the qualifying request is sampled. At that point `accept_o` is high for exactly one cycle and `ack_o` has exactly one bit set: the bit at the winner's index. Otherwise `ack_o` is all zero.
- R5: When `accept_o` is high, `vec_code_o` holds the winner's line index and `vec_addr_o` holds the table base (0 by default) plus four times that index.
- R6: When a request is accepted, the current level becomes the winner's level (index+1) in the same cycle that `accept_o` goes high. The level that was in force before is saved.
- R7: A return pulse sets the current level, one clock later, to the most recently saved level and discards that saved entry. Saved levels come back in last-in, first-out order.
- R8: A level write sets the current level to the written value one clock later. No request is accepted in a write cycle.
- R9: If a return pulse and a level write arrive in the same cycle, the return is carried out and the write is discarded. No request is accepted in a return cycle.
- R10: Up to 8 levels can be saved. An acceptance made while 8 are already saved still goes ahead, but the displaced level is lost and `stack_err_o` goes high. `stack_err_o` stays high until reset.
- R11: A return pulse when no level is saved sets the current level to 0.
- R12: Reset, which is synchronous and active high, clears the current level, `accept_o`, `ack_o`, `vec_code_o`, `vec_addr_o` (to the table base), `stack_err_o` and the save stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 32 | Device request lines; line i has level i+1 |
| int_en_i | input | 1 | Global enable for accepting requests |
| prio_wr_i | input | 1 | Pulse that writes the current level |
| prio_wdata_i | input | 6 | Level value for a write |
| ret_i | input | 1 | Return-from-service pulse that restores the saved level |
| accept_o | output | 1 | One-cycle pulse when a request is accepted |
| ack_o | output | 32 | One-hot acknowledge to the winning device |
| vec_code_o | output | 5 | Code of the accepted device |
| vec_addr_o | output | 32 | Byte address of the winner's vector table slot |
| cur_prio_o | output | 6 | Current processor level |
| stack_err_o | output | 1 | Sticky flag for a save lost on a full stack |

## Verification
The hardest state to reach from the ports is the overflow edge of the save stack, followed by unwinding it past empty. Getting there takes nine nested acceptances, each at a strictly higher level than the one before. The stimulus walks the request lines upward from line 0 to line 8, one line per cycle, and drops each request once it has been taken. It then issues nine return pulses, which must bring back levels 7 down to 0 and then land on 0 from the empty stack. Around this sequence the stimulus also drives a simultaneous return and write, and an equal-level request held across the top level, 32.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Action taken on the current level in a given cycle, in precedence order
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_RETURN = 2'd1,
        OP_WRITE  = 2'd2,
        OP_ACCEPT = 2'd3
    } lvl_op_e;

    // Return beats write, write beats accept
    function automatic lvl_op_e pick_op(input logic ret, input logic wr, input logic hit);
        if (ret)      return OP_RETURN;
        else if (wr)  return OP_WRITE;
        else if (hit) return OP_ACCEPT;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned LVL_W     = 6,
    parameter int unsigned CODE_W    = 5
) (
    input  logic [NUM_LINES-1:0] req,
    input  logic                 enable,
    input  logic [LVL_W-1:0]     cur_lvl,
    output logic                 hit,
    output logic [CODE_W-1:0]    win_code,
    output logic [NUM_LINES-1:0] win_onehot
);
    logic [NUM_LINES-1:0] elig;

    // Per-line qualification: level of line g is g+1
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_elig
        localparam logic [LVL_W-1:0] LINE_LVL = LVL_W'(g + 1);
        assign elig[g] = enable && req[g] && (LINE_LVL > cur_lvl);
    end

    // Highest index wins: later iterations override earlier ones
    always_comb begin
        hit      = 1'b0;
        win_code = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (elig[i]) begin
                hit      = 1'b1;
                win_code = CODE_W'(i);
            end
        end
    end

    assign win_onehot = hit ? (NUM_LINES'(1) << win_code) : '0;

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_lvl,
    output logic [W-1:0] top_lvl,
    output logic         empty,
    output logic         full
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     slots [DEPTH];
    logic [CNT_W-1:0] fill;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign empty  = (fill == '0);
    assign full   = (fill == CNT_W'(DEPTH));
    assign wr_ptr = PTR_W'(fill);
    assign rd_ptr = PTR_W'(fill - CNT_W'(1));
    // Popping an empty stack yields level 0
    assign top_lvl = empty ? '0 : slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else if (push && !full) begin
            fill <= fill + CNT_W'(1);
        end else if (pop && !empty) begin
            fill <= fill - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) begin
            slots[wr_ptr] <= push_lvl;
        end
    end

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned STACK_DEPTH = 8,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ENTRY_BYTES = 4,
    parameter int unsigned VEC_BASE    = 0,
    localparam int unsigned CODE_W     = $clog2(NUM_LINES),
    localparam int unsigned LVL_W      = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic                 int_en_i,
    input  logic                 prio_wr_i,
    input  logic [LVL_W-1:0]     prio_wdata_i,
    input  logic                 ret_i,
    output logic                 accept_o,
    output logic [NUM_LINES-1:0] ack_o,
    output logic [CODE_W-1:0]    vec_code_o,
    output logic [ADDR_W-1:0]    vec_addr_o,
    output logic [LVL_W-1:0]     cur_prio_o,
    output logic                 stack_err_o
);
    localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

    logic                 hit;
    logic [CODE_W-1:0]    win_code;
    logic [NUM_LINES-1:0] win_onehot;
    logic [LVL_W-1:0]     saved_lvl;
    logic                 stk_empty;
    logic                 stk_full;
    lvl_op_e              op;

    irq_prio_pick #(
        .NUM_LINES (NUM_LINES),
        .LVL_W     (LVL_W),
        .CODE_W    (CODE_W)
    ) u_pick (
        .req        (req_i),
        .enable     (int_en_i),
        .cur_lvl    (cur_prio_o),
        .hit        (hit),
        .win_code   (win_code),
        .win_onehot (win_onehot)
    );

    assign op = pick_op(ret_i, prio_wr_i, hit);

    irq_level_stack #(
        .DEPTH (STACK_DEPTH),
        .W     (LVL_W)
    ) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (op == OP_ACCEPT),
        .pop      (op == OP_RETURN),
        .push_lvl (cur_prio_o),
        .top_lvl  (saved_lvl),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_prio_o  <= '0;
            accept_o    <= 1'b0;
            ack_o       <= '0;
            vec_code_o  <= '0;
            vec_addr_o  <= ADDR_W'(VEC_BASE);
            stack_err_o <= 1'b0;
        end else begin
            accept_o <= (op == OP_ACCEPT);
            ack_o    <= (op == OP_ACCEPT) ? win_onehot : '0;
            unique case (op)
                OP_RETURN: cur_prio_o <= saved_lvl;
                OP_WRITE:  cur_prio_o <= prio_wdata_i;
                OP_ACCEPT: begin
                    cur_prio_o <= LVL_W'(win_code) + LVL_W'(1);
                    vec_code_o <= win_code;
                    vec_addr_o <= ADDR_W'(VEC_BASE) + (ADDR_W'(win_code) << SHIFT);
                    if (stk_full) stack_err_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_vec_arbiter_chk.sv
module irq_vec_arbiter_chk #(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ENTRY_BYTES = 4,
    parameter int unsigned VEC_BASE    = 0,
    parameter int unsigned CODE_W      = 5,
    parameter int unsigned LVL_W       = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] req_i,
    input logic                 int_en_i,
    input logic                 prio_wr_i,
    input logic [LVL_W-1:0]     prio_wdata_i,
    input logic                 ret_i,
    input logic                 accept_o,
    input logic [NUM_LINES-1:0] ack_o,
    input logic [CODE_W-1:0]    vec_code_o,
    input logic [ADDR_W-1:0]    vec_addr_o,
    input logic [LVL_W-1:0]     cur_prio_o,
    input logic                 stack_err_o
);
    localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

    // R1: accepted line lies strictly above the level in force before
    p_above_level_r1: assert property (@(posedge clk) disable iff (rst)
        accept_o && !$past(rst) |-> (int'(vec_code_o) + 1) > int'($past(cur_prio_o)));

    // R2, R8, R9: acceptance needs enable and neither return nor write
    p_enable_gate_r2: assert property (@(posedge clk) disable iff (rst)
        accept_o && !$past(rst) |-> $past(int_en_i) && !$past(ret_i) && !$past(prio_wr_i));

    // R3: the acknowledged line was requesting
    p_winner_requested_r3: assert property (@(posedge clk) disable iff (rst)
        accept_o && !$past(rst) |-> |($past(req_i) & ack_o));

    // R4: acknowledge is one-hot, tied to accept and to the code
    p_ack_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_o) && (accept_o == (ack_o != '0)));
    p_ack_matches_code_r4: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> ack_o[vec_code_o]);
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> !accept_o || (vec_code_o != $past(vec_code_o)));

    // R5: vector address follows the code
    p_vec_addr_r5: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> vec_addr_o == ADDR_W'(VEC_BASE) + (ADDR_W'(vec_code_o) << SHIFT));

    // R6: level becomes winner's level
    p_level_raise_r6: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> cur_prio_o == LVL_W'(vec_code_o) + LVL_W'(1));

    // R8: a write alone loads the level
    p_write_level_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(prio_wr_i) && !$past(ret_i) |-> cur_prio_o == $past(prio_wdata_i));

    // R10: error flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        stack_err_o |=> stack_err_o);

endmodule

bind irq_vec_arbiter irq_vec_arbiter_chk #(
    .NUM_LINES   (NUM_LINES),
    .ADDR_W      (ADDR_W),
    .ENTRY_BYTES (ENTRY_BYTES),
    .VEC_BASE    (VEC_BASE),
    .CODE_W      (CODE_W),
    .LVL_W       (LVL_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .int_en_i     (int_en_i),
    .prio_wr_i    (prio_wr_i),
    .prio_wdata_i (prio_wdata_i),
    .ret_i        (ret_i),
    .accept_o     (accept_o),
    .ack_o        (ack_o),
    .vec_code_o   (vec_code_o),
    .vec_addr_o   (vec_addr_o),
    .cur_prio_o   (cur_prio_o),
    .stack_err_o  (stack_err_o)
);

// File: tb/irq_vec_arbiter_tb.sv
`timescale 1ns/1ps
module irq_vec_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req_i = '0;
    logic        int_en_i = 1'b0;
    logic        prio_wr_i = 1'b0;
    logic [5:0]  prio_wdata_i = '0;
    logic        ret_i = 1'b0;
    logic        accept_o;
    logic [31:0] ack_o;
    logic [4:0]  vec_code_o;
    logic [31:0] vec_addr_o;
    logic [5:0]  cur_prio_o;
    logic        stack_err_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    irq_vec_arbiter u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .int_en_i(int_en_i),
        .prio_wr_i(prio_wr_i), .prio_wdata_i(prio_wdata_i), .ret_i(ret_i),
        .accept_o(accept_o), .ack_o(ack_o), .vec_code_o(vec_code_o),
        .vec_addr_o(vec_addr_o), .cur_prio_o(cur_prio_o), .stack_err_o(stack_err_o)
    );

    typedef struct {
        bit          acc;
        int          code;
        logic [31:0] ack;
        int          lvl;
        bit          err;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Reference model state, built from the requirements
    int m_cur = 0;
    int m_stack[$];
    bit m_err = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] rq, input bit en, input bit wr,
                        input int wd, input bit ret, input string tag);
        exp_t e;
        e.acc = 0; e.code = 0; e.ack = '0; e.tag = tag;
        if (ret) begin
            m_cur = (m_stack.size() > 0) ? m_stack.pop_back() : 0;  // R7, R11, R9
        end else if (wr) begin
            m_cur = wd;                                             // R8
        end else if (en) begin
            for (int i = 31; i >= 0; i--) begin                     // R1, R3
                if (rq[i] && (i + 1) > m_cur) begin
                    e.acc = 1; e.code = i; e.ack = 32'd1 << i;
                    break;
                end
            end
            if (e.acc) begin
                if (m_stack.size() < 8) m_stack.push_back(m_cur);
                else m_err = 1;                                     // R10
                m_cur = e.code + 1;                                 // R6
            end
        end
        e.lvl = m_cur;
        e.err = m_err;
        req_i = rq; int_en_i = en; prio_wr_i = wr; prio_wdata_i = 6'(wd); ret_i = ret;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compares after each clock edge against the scoreboard
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            if (rst) continue;
            if (sb.size() == 0) begin
                check(accept_o == 1'b0, "R4", "unexpected accept", accept_o, 0);
                continue;
            end
            e = sb.pop_front();
            check(accept_o == e.acc, e.tag, "accept", accept_o, e.acc);
            check(ack_o == e.ack, {e.tag, "/R4"}, "ack", ack_o, e.ack);
            check(int'(cur_prio_o) == e.lvl, {e.tag, "/R6"}, "level", cur_prio_o, e.lvl);
            check(stack_err_o == e.err, {e.tag, "/R10"}, "err", stack_err_o, e.err);
            if (e.acc) begin
                check(int'(vec_code_o) == e.code, {e.tag, "/R5"}, "code", vec_code_o, e.code);
                check(vec_addr_o == 32'(e.code * 4), {e.tag, "/R5"}, "addr",
                      vec_addr_o, e.code * 4);
            end
        end
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(accept_o == 0, "R12", "accept", accept_o, 0);
        check(ack_o == 0, "R12", "ack", ack_o, 0);
        check(cur_prio_o == 0, "R12", "level", cur_prio_o, 0);
        check(vec_code_o == 0, "R12", "code", vec_code_o, 0);
        check(vec_addr_o == 0, "R12", "addr", vec_addr_o, 0);
        check(stack_err_o == 0, "R12", "err", stack_err_o, 0);
        rst = 1'b0;

        step(32'hFFFF_FFFF, 0, 0, 0, 0, "R2");
        step((32'd1 << 3) | (32'd1 << 10), 1, 0, 0, 0, "R3");
        step((32'd1 << 5) | (32'd1 << 10), 1, 0, 0, 0, "R1");
        step((32'd1 << 20) | (32'd1 << 5), 1, 0, 0, 0, "R6");
        step(32'd1 << 5, 1, 0, 0, 1, "R7");
        step(32'd1 << 5, 1, 0, 0, 1, "R7");
        step(32'd1 << 5, 1, 0, 0, 0, "R4");
        step(32'd1 << 31, 1, 1, 3, 0, "R8");
        step(32'd1 << 31, 1, 0, 0, 0, "R5");
        step(32'd1 << 31, 1, 0, 0, 0, "R1");
        step(32'd0, 1, 1, 9, 1, "R9");
        step(32'd0, 1, 0, 0, 1, "R7");
        step(32'd0, 1, 0, 0, 1, "R7");
        step(32'd0, 1, 0, 0, 1, "R11");
        step(32'd0, 1, 1, 5, 0, "R8");
        step(32'd0, 1, 0, 0, 1, "R11");
        step(32'd1, 1, 0, 0, 0, "R1");
        for (int i = 1; i <= 8; i++) step(32'd1 << i, 1, 0, 0, 0, "R10");
        step(32'd1 << 8, 1, 0, 0, 0, "R1");
        for (int i = 0; i < 9; i++) step(32'd0, 1, 0, 0, 1, "R10");
        step(32'd0, 1, 1, 32, 0, "R8");
        step(32'd1 << 31, 1, 0, 0, 0, "R1");
        step(32'd0, 1, 1, 31, 0, "R8");
        step(32'd1 << 31, 1, 0, 0, 0, "R3");
        step(32'd0, 1, 0, 0, 0, "R4");
        step(32'd0, 0, 0, 0, 0, "R4");
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule